// File: doc/BRIEF.md
# Host Command and Event Status Registers

This block is the pair of 16-bit registers through which a host drives a network controller. The host writes a command word that holds an opcode for the transmit command unit and an opcode for the receive unit. Each opcode goes out to its unit as a request, and the block clears it once that unit signals that it has taken the command. The host can therefore poll the command word until both opcode fields read zero to learn that the command was accepted.

The second word is the status word. It collects single-cycle event pulses from both units into sticky flags. The host clears a flag by writing 1 to its bit. The same word also shows the live state of each unit. One interrupt output is raised while any event flag is set, unless the host has set the mask bit in the command word. If the host writes a new opcode while the previous one in that field is still waiting, the write to that field is dropped and a sticky overrun flag is raised.

Top module: `evreg_top`

## Requirements
- R1: After synchronous reset, both words read 0x0000, both opcode outputs are zero, and `irq` and `cmd_overrun` are low.
- R2: A pulse on an event input sets its status bit at the next clock edge, and the bit then stays set. The bit positions are: 15 command done, 14 frame received, 13 command unit went inactive, 12 receiver left ready, 11 management cycle done, 8 pause frame.
- R3: A write to the status word (`reg_sel`=0) clears every event bit written as 1 within the acknowledge mask 0xFD00. Bits written as 0 are unchanged, and bit 9 always reads 0.
- R4: An event pulse in the same cycle as a write-1-to-clear of its own bit wins, so the bit stays set.
- R5: A command write (`reg_sel`=1) with a nonzero value in bits 7:4 loads that command-unit opcode when none is pending. The opcode appears on `cu_opcode` and in the readback, and it reads zero from the clock edge at which `cu_take` is sampled high.
- R6: A command write with a nonzero value in bits 2:0 loads that receive-unit opcode when none is pending. The opcode appears on `ru_opcode` and in the readback, and it clears from the edge at which `ru_take` is sampled high.
- R7: A nonzero opcode written while that field is still pending leaves the pending opcode unchanged and sets `cmd_overrun`. The flag stays set until reset, and the other bits of the same write still take effect.
- R8: Command bit 8 is the interrupt mask and reads back as written. `irq` is high exactly when the mask is 0 and any event bit 15:8 is set.
- R9: A command write with bit 9 set sets status bit 10 (software interrupt). Command bits 15:9 and bit 3 always read 0.
- R10: Status bits 7:6 show `cu_state` and bits 5:2 show `ru_state` in the same cycle. The codes are idle 0, suspended 1, no resources 2 and ready 4, plus 8 for the out-of-descriptors variant (for example 0xC).
- R11: A command write whose opcode field is zero leaves a pending opcode in that field untouched and does not set `cmd_overrun`. A take pulse while nothing is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the command word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| cu_opcode | output | 4 | Pending command-unit opcode, nonzero means a request |
| cu_take | input | 1 | Command unit accepts the pending opcode |
| ru_opcode | output | 3 | Pending receive-unit opcode, nonzero means a request |
| ru_take | input | 1 | Receive unit accepts the pending opcode |
| ev_cmd_done | input | 1 | Event pulse: command finished |
| ev_frame_rx | input | 1 | Event pulse: frame received |
| ev_cu_idle | input | 1 | Event pulse: command unit left active state |
| ev_ru_notready | input | 1 | Event pulse: receiver left ready state |
| ev_mgmt_done | input | 1 | Event pulse: management read/write cycle done |
| ev_pause | input | 1 | Event pulse: flow-control pause |
| cu_state | input | 2 | Current command-unit state |
| ru_state | input | 4 | Current receive-unit state code |
| irq | output | 1 | Interrupt request |
| cmd_overrun | output | 1 | Sticky flag for a dropped opcode write |

## Verification
On every cycle the assertions check these properties: a take pulse on a pending opcode clears it; an opcode with no take stays stable; the overrun flag never falls; an event pulse always leaves its bit set, even against a clear; a software-interrupt write sets its flag; and a set mask keeps `irq` low. Only the bench scenarios can show the exact readback layout of both words, that write-1-to-clear touches only the selected bits, the live state encodings including the out-of-descriptors variants, and that the other fields of a write still take effect when one of its opcodes is dropped. These are covered by a cycle-accurate reference model that is compared on every clock.

// File: rtl/evreg_pkg.sv
package evreg_pkg;
    localparam int DW       = 16;
    localparam int CU_W     = 4;
    localparam int RU_W     = 3;
    localparam int CU_ST_W  = 2;
    localparam int RU_ST_W  = 4;
    localparam int EVT_W    = 8;
    localparam int EVT_LSB  = DW - EVT_W;

    // Writable-to-clear event positions within the upper byte (bit 9 reserved).
    localparam logic [EVT_W-1:0] EVT_ACK = 8'hFD;

    typedef struct packed {
        logic done;     // 15
        logic frame;    // 14
        logic cu_idle;  // 13
        logic ru_nr;    // 12
        logic mgmt;     // 11
        logic swi;      // 10
        logic rsvd;     // 9
        logic pause;    // 8
    } evt_t;

    typedef struct packed {
        logic [5:0]         zero_hi;
        logic               swi;
        logic               mask;
        logic [CU_W-1:0]    cu;
        logic               zero_mid;
        logic [RU_W-1:0]    ru;
    } cmd_word_t;

    typedef struct packed {
        evt_t               evt;
        logic [CU_ST_W-1:0] cu_st;
        logic [RU_ST_W-1:0] ru_st;
        logic [1:0]         zero_lo;
    } stat_word_t;

    function automatic evt_t ack_select(input logic [DW-1:0] w);
        return evt_t'(w[DW-1:EVT_LSB] & EVT_ACK);
    endfunction
endpackage

// File: rtl/evreg_cmd_slot.sv
module evreg_cmd_slot #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wval,
    input  logic         take,
    output logic [W-1:0] q,
    output logic         drop
);
    logic busy;
    logic load;

    assign busy = (q != '0);
    assign load = wr && (wval != '0);
    assign drop = load && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (busy) begin
            if (take) q <= '0;
        end else if (load) begin
            q <= wval;
        end
    end
endmodule

// File: rtl/evreg_event_bank.sv
module evreg_event_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/evreg_top.sv
module evreg_top
    import evreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic [CU_W-1:0]    cu_opcode,
    input  logic               cu_take,
    output logic [RU_W-1:0]    ru_opcode,
    input  logic               ru_take,
    input  logic               ev_cmd_done,
    input  logic               ev_frame_rx,
    input  logic               ev_cu_idle,
    input  logic               ev_ru_notready,
    input  logic               ev_mgmt_done,
    input  logic               ev_pause,
    input  logic [CU_ST_W-1:0] cu_state,
    input  logic [RU_ST_W-1:0] ru_state,
    output logic               irq,
    output logic               cmd_overrun
);
    cmd_word_t  wcmd;
    cmd_word_t  rcmd;
    stat_word_t rstat;
    evt_t       evt_set;
    evt_t       evt_clr;
    evt_t       evt_q;
    logic       cmd_wr;
    logic       stat_wr;
    logic       mask_q;
    logic       overrun_q;
    logic       cu_drop;
    logic       ru_drop;

    assign wcmd    = cmd_word_t'(reg_wdata);
    assign cmd_wr  = reg_wr && reg_sel;
    assign stat_wr = reg_wr && !reg_sel;

    evreg_cmd_slot #(.W(CU_W)) u_cu_slot (
        .clk(clk), .rst(rst), .wr(cmd_wr), .wval(wcmd.cu),
        .take(cu_take), .q(cu_opcode), .drop(cu_drop)
    );

    evreg_cmd_slot #(.W(RU_W)) u_ru_slot (
        .clk(clk), .rst(rst), .wr(cmd_wr), .wval(wcmd.ru),
        .take(ru_take), .q(ru_opcode), .drop(ru_drop)
    );

    always_comb begin
        evt_set         = '0;
        evt_set.done    = ev_cmd_done;
        evt_set.frame   = ev_frame_rx;
        evt_set.cu_idle = ev_cu_idle;
        evt_set.ru_nr   = ev_ru_notready;
        evt_set.mgmt    = ev_mgmt_done;
        evt_set.swi     = cmd_wr && wcmd.swi;
        evt_set.pause   = ev_pause;
        evt_clr         = stat_wr ? ack_select(reg_wdata) : evt_t'('0);
    end

    evreg_event_bank #(.W(EVT_W)) u_events (
        .clk(clk), .rst(rst), .set(evt_set), .clr(evt_clr), .q(evt_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            if (cmd_wr) mask_q <= wcmd.mask;
            if (cu_drop || ru_drop) overrun_q <= 1'b1;
        end
    end

    always_comb begin
        rcmd       = '0;
        rcmd.mask  = mask_q;
        rcmd.cu    = cu_opcode;
        rcmd.ru    = ru_opcode;
        rstat      = '0;
        rstat.evt  = evt_q;
        rstat.cu_st = cu_state;
        rstat.ru_st = ru_state;
        reg_rdata  = reg_sel ? DW'(rcmd) : DW'(rstat);
    end

    assign irq         = !mask_q && (evt_q != '0);
    assign cmd_overrun = overrun_q;
endmodule

// File: rtl/evreg_chk.sv
module evreg_chk
    import evreg_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            reg_wr,
    input logic            reg_sel,
    input logic [DW-1:0]   reg_wdata,
    input logic [DW-1:0]   reg_rdata,
    input logic [CU_W-1:0] cu_opcode,
    input logic            cu_take,
    input logic [RU_W-1:0] ru_opcode,
    input logic            ru_take,
    input logic            ev_cmd_done,
    input logic            ev_pause,
    input evt_t            evt_q,
    input logic            irq,
    input logic            cmd_overrun
);
    p_cu_take_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (cu_opcode != '0 && cu_take) |=> (cu_opcode == '0));

    p_ru_take_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ru_opcode != '0 && ru_take) |=> (ru_opcode == '0));

    p_cu_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cu_opcode != '0 && !cu_take) |=> $stable(cu_opcode));

    p_ru_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ru_opcode != '0 && !ru_take) |=> $stable(ru_opcode));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_overrun |=> cmd_overrun);

    p_zero_write_no_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && reg_wdata == '0 && !cmd_overrun) |=> !cmd_overrun);

    p_set_wins_done_r4: assert property (@(posedge clk) disable iff (rst)
        ev_cmd_done |=> evt_q.done);

    p_set_wins_pause_r4: assert property (@(posedge clk) disable iff (rst)
        ev_pause |=> evt_q.pause);

    p_swi_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && reg_wdata[9]) |=> evt_q.swi);

    p_mask_blocks_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_rdata[8]) |-> !irq);
endmodule

bind evreg_top evreg_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cu_opcode(cu_opcode), .cu_take(cu_take),
    .ru_opcode(ru_opcode), .ru_take(ru_take),
    .ev_cmd_done(ev_cmd_done), .ev_pause(ev_pause),
    .evt_q(evt_q), .irq(irq), .cmd_overrun(cmd_overrun)
);

// File: tb/evreg_top_tb.sv
module evreg_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  cu_opcode;
    logic        cu_take = 1'b0;
    logic [2:0]  ru_opcode;
    logic        ru_take = 1'b0;
    logic        ev_cmd_done = 1'b0, ev_frame_rx = 1'b0, ev_cu_idle = 1'b0;
    logic        ev_ru_notready = 1'b0, ev_mgmt_done = 1'b0, ev_pause = 1'b0;
    logic [1:0]  cu_state = '0;
    logic [3:0]  ru_state = '0;
    logic        irq;
    logic        cmd_overrun;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_evt = '0;
    logic [3:0] m_cu = '0;
    logic [2:0] m_ru = '0;
    logic       m_mask = 1'b0;
    logic       m_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evreg_top u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cu_opcode(cu_opcode), .cu_take(cu_take),
        .ru_opcode(ru_opcode), .ru_take(ru_take),
        .ev_cmd_done(ev_cmd_done), .ev_frame_rx(ev_frame_rx),
        .ev_cu_idle(ev_cu_idle), .ev_ru_notready(ev_ru_notready),
        .ev_mgmt_done(ev_mgmt_done), .ev_pause(ev_pause),
        .cu_state(cu_state), .ru_state(ru_state),
        .irq(irq), .cmd_overrun(cmd_overrun)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        if (reg_sel)
            return {7'd0, m_mask, m_cu, 1'b0, m_ru};
        return {m_evt, cu_state, ru_state, 2'b00};
    endfunction

    task automatic compare(input string tag);
        chk(tag, "rdata", reg_rdata, exp_rdata());
        chk(tag, "cu_opcode", 16'(cu_opcode), 16'(m_cu));
        chk(tag, "ru_opcode", 16'(ru_opcode), 16'(m_ru));
        chk(tag, "irq", 16'(irq), 16'(!m_mask && (m_evt != 0)));
        chk(tag, "overrun", 16'(cmd_overrun), 16'(m_err));
    endtask

    // One clock: predict from inputs held across the edge, then compare.
    task automatic tick(input string tag);
        logic [7:0] n_evt;
        logic [3:0] n_cu;
        logic [2:0] n_ru;
        logic       n_mask, n_err;
        logic       cw, sw;
        cw = reg_wr && reg_sel;
        sw = reg_wr && !reg_sel;
        n_evt = m_evt;
        if (sw) n_evt = n_evt & ~(reg_wdata[15:8] & 8'hFD);
        n_evt = n_evt | {ev_cmd_done, ev_frame_rx, ev_cu_idle, ev_ru_notready,
                         ev_mgmt_done, cw && reg_wdata[9], 1'b0, ev_pause};
        n_cu = m_cu;
        n_ru = m_ru;
        n_err = m_err;
        if (m_cu == 0 && cw) n_cu = reg_wdata[7:4];
        if (m_cu != 0 && cu_take) n_cu = 0;
        if (m_cu != 0 && cw && reg_wdata[7:4] != 0) n_err = 1'b1;
        if (m_ru == 0 && cw) n_ru = reg_wdata[2:0];
        if (m_ru != 0 && ru_take) n_ru = 0;
        if (m_ru != 0 && cw && reg_wdata[2:0] != 0) n_err = 1'b1;
        n_mask = cw ? reg_wdata[8] : m_mask;
        @(posedge clk);
        #1;
        if (rst) begin
            m_evt = '0; m_cu = '0; m_ru = '0; m_mask = 1'b0; m_err = 1'b0;
        end else begin
            m_evt = n_evt; m_cu = n_cu; m_ru = n_ru; m_mask = n_mask; m_err = n_err;
        end
        compare(tag);
    endtask

    task automatic write(input logic sel, input logic [15:0] d, input string tag);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick(tag);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) tick("R1");
        rst = 1'b0;
        tick("R1");
        reg_sel = 1'b0; #1;
        chk("R1", "status after reset", reg_rdata, 16'h0000);
        reg_sel = 1'b1; #1;
        chk("R1", "command after reset", reg_rdata, 16'h0000);

        // R10 live unit states
        reg_sel = 1'b0; cu_state = 2'd2; ru_state = 4'hC; #1;
        chk("R10", "states C", reg_rdata, 16'h00B0);
        ru_state = 4'h2; #1;
        chk("R10", "states 2", reg_rdata, 16'h0088);
        cu_state = 2'd1; ru_state = 4'h4; tick("R10");

        // R5/R6 load, forward, take
        write(1'b1, 16'h0021, "R5");
        reg_sel = 1'b1; #1;
        chk("R5", "cu opcode loaded", 16'(cu_opcode), 16'h2);
        chk("R6", "ru opcode loaded", 16'(ru_opcode), 16'h1);
        chk("R5", "command readback", reg_rdata, 16'h0021);
        cu_take = 1'b1; tick("R5"); cu_take = 1'b0;
        chk("R5", "cu cleared after take", reg_rdata, 16'h0001);
        ru_take = 1'b1; tick("R6"); ru_take = 1'b0;
        chk("R6", "ru cleared after take", reg_rdata, 16'h0000);

        // R11 idle take ignored, zero field keeps pending
        cu_take = 1'b1; ru_take = 1'b1; tick("R11"); cu_take = 1'b0; ru_take = 1'b0;
        chk("R11", "idle take", reg_rdata, 16'h0000);
        write(1'b1, 16'h0040, "R11");
        write(1'b1, 16'h0006, "R11");
        chk("R11", "both pending", reg_rdata, 16'h0046);
        write(1'b1, 16'h0000, "R11");
        chk("R11", "zero write keeps", reg_rdata, 16'h0046);
        chk("R11", "no overrun", 16'(cmd_overrun), 16'h0);
        cu_take = 1'b1; ru_take = 1'b1; tick("R11"); cu_take = 1'b0; ru_take = 1'b0;

        // R7 overrun
        write(1'b1, 16'h0011, "R7");
        write(1'b1, 16'h0152, "R7");
        chk("R7", "pending kept, mask taken", reg_rdata, 16'h0111);
        chk("R7", "overrun set", 16'(cmd_overrun), 16'h1);
        cu_take = 1'b1; ru_take = 1'b1; tick("R7"); cu_take = 1'b0; ru_take = 1'b0;
        write(1'b1, 16'h0000, "R7");
        chk("R7", "overrun sticky", 16'(cmd_overrun), 16'h1);

        // R2 events
        cu_state = 2'd0; ru_state = 4'h0; reg_sel = 1'b0;
        ev_cmd_done = 1'b1; ev_pause = 1'b1; tick("R2");
        ev_cmd_done = 1'b0; ev_pause = 1'b0; tick("R2");
        chk("R2", "done+pause held", reg_rdata, 16'h8100);
        chk("R8", "irq unmasked", 16'(irq), 16'h1);

        // R8 mask
        write(1'b1, 16'h0100, "R8");
        chk("R8", "irq masked", 16'(irq), 16'h0);
        chk("R8", "mask readback", reg_rdata, 16'h0100);
        write(1'b1, 16'h0000, "R8");
        chk("R8", "irq unmasked again", 16'(irq), 16'h1);

        // R3 write-1-to-clear
        write(1'b0, 16'h0100, "R3");
        chk("R3", "pause cleared only", reg_rdata, 16'h8000);
        write(1'b0, 16'h0000, "R3");
        chk("R3", "zero write no effect", reg_rdata, 16'h8000);
        write(1'b0, 16'h8000, "R3");
        chk("R3", "done cleared", reg_rdata, 16'h0000);
        chk("R8", "irq low when empty", 16'(irq), 16'h0);
        ev_mgmt_done = 1'b1; ev_cu_idle = 1'b1; ev_ru_notready = 1'b1; tick("R2");
        ev_mgmt_done = 1'b0; ev_cu_idle = 1'b0; ev_ru_notready = 1'b0;
        chk("R2", "mgmt/cu/ru events", reg_rdata, 16'h3800);
        write(1'b0, 16'hFFFF, "R3");
        chk("R3", "clear all", reg_rdata, 16'h0000);

        // R4 set beats clear
        ev_frame_rx = 1'b1; write(1'b0, 16'h4000, "R4"); ev_frame_rx = 1'b0;
        chk("R4", "frame stays set", reg_rdata, 16'h4000);
        write(1'b0, 16'h4000, "R4");
        chk("R4", "frame cleared later", reg_rdata, 16'h0000);

        // R9 software interrupt
        write(1'b1, 16'h0200, "R9");
        chk("R9", "command bit 9 reads 0", reg_rdata, 16'h0000);
        reg_sel = 1'b0; #1;
        chk("R9", "swi status", reg_rdata, 16'h0400);
        write(1'b1, 16'hFC08, "R9");
        chk("R9", "unused command bits read 0", reg_rdata, 16'h0000);
        write(1'b0, 16'h0400, "R9");
        chk("R9", "swi cleared", reg_rdata, 16'h0000);

        tick("R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule